// File: doc/BRIEF.md
# Tile Dword Transpose Unit

This unit reorders the 32-bit elements of a square tile so that columns become rows. The source tile is sixteen rows of sixty-four bytes, presented all at once on one wide read bus. After a start pulse, the unit emits one destination row per cycle on a row write port. Destination row i, element j takes source row j, element i.

The shape of the destination comes from two values that the unit captures at start: a row count and a width in bytes. Elements beyond the configured width are written as zero. Rows at or beyond the configured row count are written as zero. All sixteen destination rows are always written, so the tile that results never holds stale data.

Once the last row has been written, the unit raises a one-cycle done pulse. In the same cycle it raises a pulse that clears the restart pointer held in the tile configuration. If the shape is illegal, the unit writes nothing and raises a one-cycle error pulse instead. The source bus must stay stable while the unit is busy.

Top module: `tile_xpose_unit`

## Requirements
- R1: After reset, wr_en_o, busy_o, done_o, err_o and cfg_restart_clr_o are all low.
- R2: A start with a legal shape, accepted while idle, produces exactly 16 consecutive write cycles. They begin the cycle after start and carry wr_row_o = 0, 1, ..., 15 in order, with busy_o high in each of them.
- R3: In a write of destination row i, when i < rows and j < colsb/4, element j of the row equals element i of source row j. Element j of a row occupies bits [32j+31:32j] of wr_data_o. Source row r occupies bits [512r+511:512r] of src_tile_i.
- R4: In a write of destination row i < rows, every element j >= colsb/4 is zero.
- R5: Every destination row i >= rows is written as all zero.
- R6: done_o and cfg_restart_clr_o are high for exactly one cycle, the cycle after the write of row 15. busy_o is low in that cycle.
- R7: A shape is illegal when colsb is not a multiple of 4, when colsb > 64, or when rows > 16. A start with an illegal shape performs no write. It raises err_o for one cycle, the cycle after start, and raises neither done_o nor cfg_restart_clr_o.
- R8: A start_i pulse while busy_o, done_o or err_o is high is ignored. The running sequence and its captured shape are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| dst_rows_i | input | 6 | Destination row count (unsigned) |
| dst_colsb_i | input | 8 | Destination width in bytes (unsigned) |
| src_tile_i | input | 8192 | Whole source tile, row r at bits [512r+511:512r] |
| wr_en_o | output | 1 | Destination row write strobe |
| wr_row_o | output | 4 | Destination row index |
| wr_data_o | output | 512 | Destination row data |
| busy_o | output | 1 | Transpose in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle illegal-shape pulse |
| cfg_restart_clr_o | output | 1 | One-cycle clear of the configuration restart pointer |

## Verification
The bench builds the unit with its default parameters: 16 rows of 64 bytes and 32-bit elements. This covers the full square tile, so the extreme shapes can all be reached. These include full height with full width, zero rows, zero width, a single element column, and widths just short of the limit. It also covers every kind of illegal shape: a width that is not a multiple of four, a width over the limit, and too many rows. A behavioural model predicts every output in every cycle, including when a start that arrives mid-run is ignored.

// File: rtl/tile_xpose_pkg.sv
package tile_xpose_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2,
    ST_ERR  = 2'd3
  } xp_state_e;
endpackage

// File: rtl/tile_xpose_cfg_chk.sv
module tile_xpose_cfg_chk #(
  parameter int NUM_ROWS   = 16,
  parameter int ROW_BYTES  = 64,
  parameter int ELEM_BYTES = 4,
  parameter int RW         = 6,
  parameter int CBW        = 8
) (
  input  logic [RW-1:0]  rows_i,
  input  logic [CBW-1:0] colsb_i,
  output logic           ok_o,
  output logic [CBW-1:0] ncols_o
);
  localparam int EB_LG = $clog2(ELEM_BYTES);

  logic aligned, width_ok, rows_ok;

  assign aligned  = (colsb_i[EB_LG-1:0] == '0);
  assign width_ok = (int'(colsb_i) <= ROW_BYTES);
  assign rows_ok  = (int'(rows_i) <= NUM_ROWS);
  assign ok_o     = aligned && width_ok && rows_ok;
  assign ncols_o  = colsb_i >> EB_LG;
endmodule

// File: rtl/tile_xpose_seq.sv
module tile_xpose_seq
  import tile_xpose_pkg::*;
#(
  parameter int NUM_ROWS = 16,
  parameter int RIW      = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           cfg_ok_i,
  output logic           load_o,
  output logic [RIW-1:0] row_o,
  output logic           wr_en_o,
  output logic           busy_o,
  output logic           done_o,
  output logic           err_o
);
  localparam logic [RIW-1:0] LAST_ROW = RIW'(NUM_ROWS - 1);

  xp_state_e state_q;
  logic [RIW-1:0] cnt_q;

  assign load_o = (state_q == ST_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= cfg_ok_i ? ST_RUN : ST_ERR;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          if (cnt_q == LAST_ROW) state_q <= ST_DONE;
          else                   cnt_q   <= cnt_q + 1'b1;
        end
        ST_DONE: state_q <= ST_IDLE;
        ST_ERR:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign row_o   = cnt_q;
  assign wr_en_o = (state_q == ST_RUN);
  assign busy_o  = (state_q == ST_RUN);
  assign done_o  = (state_q == ST_DONE);
  assign err_o   = (state_q == ST_ERR);

  AST_ROW_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && row_o != LAST_ROW) |=> (wr_en_o && row_o == $past(row_o) + 1'b1)); // R2
  AST_FIRST_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(wr_en_o)) |-> (row_o == '0)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(wr_en_o) && $past(row_o) == LAST_ROW)); // R6
  AST_ERR_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!wr_en_o && !done_o && !$past(wr_en_o))); // R7
  AST_ONE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({busy_o, done_o, err_o})); // R8
endmodule

// File: rtl/tile_xpose_gather.sv
module tile_xpose_gather #(
  parameter int NUM_ROWS  = 16,
  parameter int ELEMS     = 16,
  parameter int ELEM_BITS = 32,
  parameter int RIW       = 4,
  parameter int RW        = 6,
  parameter int CBW       = 8
) (
  input  logic [NUM_ROWS*ELEMS*ELEM_BITS-1:0] src_tile_i,
  input  logic [RIW-1:0]                      row_i,
  input  logic [RW-1:0]                       rows_i,
  input  logic [CBW-1:0]                      ncols_i,
  output logic [ELEMS*ELEM_BITS-1:0]          data_o
);
  logic row_live;
  assign row_live = ({{(RW > RIW ? RW-RIW : 1){1'b0}}, row_i} < {{(RW > RIW ? 0 : 1){1'b0}}, rows_i});

  for (genvar j = 0; j < ELEMS; j++) begin : g_elem
    logic [ELEM_BITS-1:0] elem;
    logic                 col_live;
    if (j < NUM_ROWS) begin : g_src
      assign elem = src_tile_i[(j*ELEMS + int'(row_i))*ELEM_BITS +: ELEM_BITS];
    end else begin : g_pad
      assign elem = '0;
    end
    assign col_live = (CBW'(j) < ncols_i);
    assign data_o[j*ELEM_BITS +: ELEM_BITS] = (row_live && col_live) ? elem : '0;
  end
endmodule

// File: rtl/tile_xpose_unit.sv
module tile_xpose_unit #(
  parameter int NUM_ROWS  = 16,
  parameter int ROW_BYTES = 64,
  parameter int ELEM_BITS = 32,
  localparam int ELEM_BYTES = ELEM_BITS / 8,
  localparam int ELEMS      = ROW_BYTES / ELEM_BYTES,
  localparam int ROW_BITS   = ROW_BYTES * 8,
  localparam int RIW        = $clog2(NUM_ROWS),
  localparam int RW         = $clog2(NUM_ROWS + 1) + 1,
  localparam int CBW        = $clog2(ROW_BYTES + 1) + 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic [RW-1:0]                dst_rows_i,
  input  logic [CBW-1:0]               dst_colsb_i,
  input  logic [NUM_ROWS*ROW_BITS-1:0] src_tile_i,
  output logic                         wr_en_o,
  output logic [RIW-1:0]               wr_row_o,
  output logic [ROW_BITS-1:0]          wr_data_o,
  output logic                         busy_o,
  output logic                         done_o,
  output logic                         err_o,
  output logic                         cfg_restart_clr_o
);
  logic           cfg_ok, load;
  logic [CBW-1:0] ncols_in, ncols_q;
  logic [RW-1:0]  rows_q;
  logic [RIW-1:0] row;

  tile_xpose_cfg_chk #(
    .NUM_ROWS(NUM_ROWS), .ROW_BYTES(ROW_BYTES), .ELEM_BYTES(ELEM_BYTES),
    .RW(RW), .CBW(CBW)
  ) u_chk (
    .rows_i (dst_rows_i),
    .colsb_i(dst_colsb_i),
    .ok_o   (cfg_ok),
    .ncols_o(ncols_in)
  );

  tile_xpose_seq #(.NUM_ROWS(NUM_ROWS), .RIW(RIW)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .cfg_ok_i(cfg_ok),
    .load_o  (load),
    .row_o   (row),
    .wr_en_o (wr_en_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .err_o   (err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rows_q  <= '0;
      ncols_q <= '0;
    end else if (load && cfg_ok) begin
      rows_q  <= dst_rows_i;
      ncols_q <= ncols_in;
    end
  end

  tile_xpose_gather #(
    .NUM_ROWS(NUM_ROWS), .ELEMS(ELEMS), .ELEM_BITS(ELEM_BITS),
    .RIW(RIW), .RW(RW), .CBW(CBW)
  ) u_gather (
    .src_tile_i(src_tile_i),
    .row_i     (row),
    .rows_i    (rows_q),
    .ncols_i   (ncols_q),
    .data_o    (wr_data_o)
  );

  assign wr_row_o          = row;
  assign cfg_restart_clr_o = done_o;

  AST_CFG_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(rows_q) && $stable(ncols_q))); // R8
  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && RW'(wr_row_o) >= rows_q) |-> (wr_data_o == '0)); // R5
  AST_WR_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> busy_o); // R2
endmodule

// File: tb/tile_xpose_unit_bench.sv
`timescale 1ns/1ps
module tile_xpose_unit_bench;
  localparam int NR = 16;
  localparam int NE = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [5:0]    dst_rows_i = '0;
  logic [7:0]    dst_colsb_i = '0;
  logic [8191:0] src_tile_i = '0;
  logic          wr_en_o, busy_o, done_o, err_o, cfg_restart_clr_o;
  logic [3:0]    wr_row_o;
  logic [511:0]  wr_data_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk_i = ~clk_i;

  tile_xpose_unit u_tile_xpose_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .dst_rows_i(dst_rows_i), .dst_colsb_i(dst_colsb_i), .src_tile_i(src_tile_i),
    .wr_en_o(wr_en_o), .wr_row_o(wr_row_o), .wr_data_o(wr_data_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .cfg_restart_clr_o(cfg_restart_clr_o)
  );

  // reference model: 0 idle, 1 run, 2 done, 3 err
  int m_state = 0;
  int m_cnt = 0;
  int m_rows = 0;
  int m_cols = 0;

  always @(posedge clk_i) begin
    cycles++;
    if (!rst_ni) begin
      m_state = 0; m_cnt = 0;
    end else begin
      case (m_state)
        0: if (start_i) begin
          if ((dst_colsb_i % 4) == 0 && dst_colsb_i <= 64 && dst_rows_i <= 16) begin
            m_state = 1; m_rows = dst_rows_i; m_cols = dst_colsb_i / 4;
          end else m_state = 3;
          m_cnt = 0;
        end
        1: if (m_cnt == NR-1) m_state = 2; else m_cnt++;
        default: m_state = 0;
      endcase
    end
  end

  function automatic logic [511:0] exp_row(int k);
    logic [511:0] r = '0;
    for (int j = 0; j < NE; j++)
      if (k < m_rows && j < m_cols) r[j*32 +: 32] = src_tile_i[(j*NE + k)*32 +: 32];
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk(wr_en_o == (m_state == 1), "R2", "wr_en", 512'(wr_en_o), 512'(m_state == 1));
      chk(busy_o == (m_state == 1), "R2", "busy", 512'(busy_o), 512'(m_state == 1));
      chk(done_o == (m_state == 2), "R6", "done", 512'(done_o), 512'(m_state == 2));
      chk(cfg_restart_clr_o == (m_state == 2), "R6", "restart_clr", 512'(cfg_restart_clr_o), 512'(m_state == 2));
      chk(err_o == (m_state == 3), "R7", "err", 512'(err_o), 512'(m_state == 3));
      if (m_state == 1) begin
        chk(wr_row_o == 4'(m_cnt), "R2", "row", 512'(wr_row_o), 512'(m_cnt));
        chk(wr_data_o == exp_row(m_cnt), (m_cnt >= m_rows) ? "R5" : "R3 R4", "data",
            wr_data_o, exp_row(m_cnt));
      end
    end
  end

  task automatic fill_src(int seed);
    for (int r = 0; r < NR; r++)
      for (int e = 0; e < NE; e++)
        src_tile_i[(r*NE + e)*32 +: 32] = {8'(seed), 8'(r), 8'(e), 8'(seed*7 + r*3 + e)};
  endtask

  task automatic launch(int rows, int colsb);
    @(negedge clk_i);
    start_i = 1'b1; dst_rows_i = 6'(rows); dst_colsb_i = 8'(colsb);
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (20) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk({wr_en_o, busy_o, done_o, err_o, cfg_restart_clr_o} == 5'b0, "R1", "reset outputs",
        512'({wr_en_o, busy_o, done_o, err_o, cfg_restart_clr_o}), 512'(0));
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    fill_src(1);  launch(16, 64);  // R3 full tile
    fill_src(2);  launch(5, 20);   // R4 R5 partial
    fill_src(3);  launch(0, 64);   // R5 zero rows
    launch(16, 0);                 // R4 zero width
    fill_src(4);  launch(1, 4);
    launch(15, 60);
    launch(4, 18);                 // R7 misaligned
    launch(4, 68);                 // R7 too wide
    launch(17, 64);                // R7 too many rows
    // R8 restart attempt while busy with different shape
    fill_src(5);
    @(negedge clk_i);
    start_i = 1'b1; dst_rows_i = 6'd8; dst_colsb_i = 8'd32;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    start_i = 1'b1; dst_rows_i = 6'd2; dst_colsb_i = 8'd8;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (12) @(negedge clk_i);
    start_i = 1'b1; dst_rows_i = 6'd17;  // lands in done cycle, ignored
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (20) @(negedge clk_i);
    launch(8, 36);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=<5000", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule